// File: doc/BRIEF.md
# Exception Return Address Register Bank

This block keeps the saved exception return addresses for the three privilege levels: machine, supervisor and user. Two sources write the registers. One is the CSR write port, which uses a valid/ready pair. The other is the trap-capture port, a plain strobe that is always accepted. Each register is read in two ways: through the CSR read port, and as the return-from-trap target selected by a separate privilege code. Both read paths are combinational.

Two settings decide alignment. The parameter `HAS_C` says whether the design supports 16-bit instructions at all. The input `c_enable` says whether they are enabled right now. Writes and reads are legalized separately:

- **Writes** always clear bit 0. With `HAS_C` = 1 they keep bit 1. With `HAS_C` = 0 they clear bit 1 as well.
- **Reads** hide bit 1 while 16-bit instructions are off. The stored bit keeps its value, so it shows again when they are turned back on.

CSR write back-pressure rule: `csr_wr_ready` falls only when a trap capture targets the same valid privilege in the same cycle. A CSR write takes effect only on a clock edge where `csr_wr_valid` and `csr_wr_ready` are both high. When `ready` is low the write is dropped, not held. The issuing instruction loses to the trap.

Top module: `epc_bank`

## Requirements
- R1: After reset, all three registers read as zero on both read paths.
- R2: Every stored value has bit 0 equal to zero, whether it came from the CSR port or the trap port. Both read paths always show bit 0 as zero.
- R3: With `HAS_C` = 0, writes clear bits 1:0, and both read paths show bits 1:0 as zero regardless of `c_enable`.
- R4: With `HAS_C` = 1, bit 1 is stored as written even while `c_enable` is low. It reappears on the read paths once `c_enable` is high, with no new write.
- R5: With `HAS_C` = 1 and `c_enable` high, a read returns the stored value with only bit 0 clear. With `c_enable` low, bits 1:0 read as zero.
- R6: `ret_target` applies the same read masking as `csr_rd_data`, to the register chosen by `ret_priv`.
- R7: Privilege codes are 2'b00 user, 2'b01 supervisor and 2'b11 machine. Code 2'b10 is reserved: it reads as zero on both paths, and writes with it change no register.
- R8: A trap capture (`trap_valid` high) to a privilege takes priority over a CSR write to the same privilege in that cycle. `csr_wr_ready` is low in exactly that case. The trap value passes through the same write legalization. A CSR write to a different privilege in the same cycle still completes.
- R9: Writes become visible one clock edge later. A register that is not written keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c_enable | input | 1 | 16-bit instructions currently enabled |
| csr_priv | input | 2 | Privilege code for the CSR read and write |
| csr_wr_valid | input | 1 | CSR write request |
| csr_wr_ready | output | 1 | CSR write can be accepted this cycle |
| csr_wr_data | input | XLEN | CSR write value |
| csr_rd_data | output | XLEN | Legalized read of the selected register |
| trap_valid | input | 1 | Trap-entry capture strobe |
| trap_priv | input | 2 | Privilege code receiving the trap PC |
| trap_pc | input | XLEN | PC captured on trap entry |
| ret_priv | input | 2 | Privilege code of the xRET being executed |
| ret_target | output | XLEN | Legalized return address |

## Verification
The hardest case to reach is a value whose bit 1 was written while `c_enable` was low. It must stay hidden until a later cycle raises `c_enable`, and then appear without another write. A directed sequence writes with compression off, reads back, and then re-enables compression. Random stimulus also toggles `c_enable` independently of the writes, so the same case arises on every privilege and through both the CSR and trap ports. Same-privilege collisions between a trap and a CSR write are rare at random, so a directed case forces them alongside a write to a different privilege.

// File: rtl/epc_pkg.sv
package epc_pkg;
  localparam int NSLOT = 3;

  typedef enum logic [1:0] {
    PRIV_U    = 2'b00,
    PRIV_S    = 2'b01,
    PRIV_RSVD = 2'b10,
    PRIV_M    = 2'b11
  } priv_e;

  function automatic logic [1:0] slot_code(input int k);
    case (k)
      0:       return PRIV_U;
      1:       return PRIV_S;
      default: return PRIV_M;
    endcase
  endfunction

  function automatic logic code_ok(input logic [1:0] c);
    return c != PRIV_RSVD;
  endfunction
endpackage

// File: rtl/epc_wr_legal.sv
module epc_wr_legal #(
  parameter int XLEN  = 32,
  parameter bit HAS_C = 1'b1
) (
  input  logic [XLEN-1:0] raw,
  output logic [XLEN-1:0] legal
);
  localparam logic [XLEN-1:0] KEEP = {{(XLEN-2){1'b1}}, HAS_C, 1'b0};

  assign legal = raw & KEEP;
endmodule

// File: rtl/epc_rd_legal.sv
module epc_rd_legal #(
  parameter int XLEN  = 32,
  parameter bit HAS_C = 1'b1
) (
  input  logic [XLEN-1:0] stored,
  input  logic            c_enable,
  output logic [XLEN-1:0] view
);
  logic c_on;
  assign c_on = c_enable & HAS_C;
  assign view = stored & {{(XLEN-2){1'b1}}, c_on, 1'b0};
endmodule

// File: rtl/epc_slot.sv
module epc_slot #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_hit,
  input  logic [XLEN-1:0] trap_val,
  input  logic            csr_hit,
  input  logic [XLEN-1:0] csr_val,
  output logic [XLEN-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (trap_hit) q <= trap_val;
    else if (csr_hit)  q <= csr_val;
  end

  a_r8_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit |=> q == $past(trap_val));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_hit && !csr_hit) |=> $stable(q));
  a_r9_csr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_hit && !trap_hit) |=> q == $past(csr_val));
endmodule

// File: rtl/epc_bank.sv
module epc_bank
  import epc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter bit HAS_C = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            c_enable,
  input  logic [1:0]      csr_priv,
  input  logic            csr_wr_valid,
  output logic            csr_wr_ready,
  input  logic [XLEN-1:0] csr_wr_data,
  output logic [XLEN-1:0] csr_rd_data,
  input  logic            trap_valid,
  input  logic [1:0]      trap_priv,
  input  logic [XLEN-1:0] trap_pc,
  input  logic [1:0]      ret_priv,
  output logic [XLEN-1:0] ret_target
);
  logic [XLEN-1:0] trap_legal, csr_legal;
  logic [XLEN-1:0] slot_q [NSLOT];
  logic [XLEN-1:0] csr_raw, ret_raw;
  logic            csr_fire;

  epc_wr_legal #(.XLEN(XLEN), .HAS_C(HAS_C)) u_wl_trap (.raw(trap_pc),     .legal(trap_legal));
  epc_wr_legal #(.XLEN(XLEN), .HAS_C(HAS_C)) u_wl_csr  (.raw(csr_wr_data), .legal(csr_legal));

  assign csr_wr_ready = !(trap_valid && code_ok(csr_priv) && (trap_priv == csr_priv));
  assign csr_fire     = csr_wr_valid && csr_wr_ready;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam logic [1:0] CODE = slot_code(k);
    logic trap_hit, csr_hit;
    assign trap_hit = trap_valid && (trap_priv == CODE);
    assign csr_hit  = csr_fire && (csr_priv == CODE);
    epc_slot #(.XLEN(XLEN)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .trap_hit(trap_hit),
      .trap_val(trap_legal),
      .csr_hit (csr_hit),
      .csr_val (csr_legal),
      .q       (slot_q[k])
    );
  end

  always_comb begin
    case (csr_priv)
      PRIV_U:  csr_raw = slot_q[0];
      PRIV_S:  csr_raw = slot_q[1];
      PRIV_M:  csr_raw = slot_q[2];
      default: csr_raw = '0;
    endcase
    case (ret_priv)
      PRIV_U:  ret_raw = slot_q[0];
      PRIV_S:  ret_raw = slot_q[1];
      PRIV_M:  ret_raw = slot_q[2];
      default: ret_raw = '0;
    endcase
  end

  epc_rd_legal #(.XLEN(XLEN), .HAS_C(HAS_C)) u_rl_csr (
    .stored(csr_raw), .c_enable(c_enable), .view(csr_rd_data));
  epc_rd_legal #(.XLEN(XLEN), .HAS_C(HAS_C)) u_rl_ret (
    .stored(ret_raw), .c_enable(c_enable), .view(ret_target));

  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (slot_q[0] == '0 && slot_q[1] == '0 && slot_q[2] == '0));
  a_r2_bit0_low: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_q[0][0] && !slot_q[1][0] && !slot_q[2][0]);
  a_r5_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
    !c_enable |-> (csr_rd_data[1:0] == 2'b00 && ret_target[1:0] == 2'b00));
  a_r7_rsvd_read: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_priv == PRIV_RSVD) |-> csr_rd_data == '0);
  a_r8_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_priv == csr_priv && trap_priv != PRIV_RSVD) |-> !csr_wr_ready);
  a_r8_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |-> csr_wr_ready);

  if (!HAS_C) begin : g_noc_chk
    a_r3_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q[0][1:0] == 2'b00 && slot_q[1][1:0] == 2'b00 && slot_q[2][1:0] == 2'b00);
  end
endmodule

// File: tb/epc_bank_tb_top.sv
module epc_bank_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c_enable = 1'b1;
  logic [1:0] csr_priv = 2'b00, trap_priv = 2'b00, ret_priv = 2'b00;
  logic csr_wr_valid = 1'b0, trap_valid = 1'b0;
  logic [W-1:0] csr_wr_data = '0, trap_pc = '0;
  logic rdy_c, rdy_n;
  logic [W-1:0] rd_c, ret_c, rd_n, ret_n;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_c [3];
  logic [W-1:0] exp_n [3];

  always #5 clk = ~clk;

  epc_bank #(.XLEN(W), .HAS_C(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .c_enable(c_enable), .csr_priv(csr_priv),
    .csr_wr_valid(csr_wr_valid), .csr_wr_ready(rdy_c), .csr_wr_data(csr_wr_data),
    .csr_rd_data(rd_c), .trap_valid(trap_valid), .trap_priv(trap_priv),
    .trap_pc(trap_pc), .ret_priv(ret_priv), .ret_target(ret_c));

  epc_bank #(.XLEN(W), .HAS_C(1'b0)) dut_nc_i (
    .clk(clk), .rst_n(rst_n), .c_enable(c_enable), .csr_priv(csr_priv),
    .csr_wr_valid(csr_wr_valid), .csr_wr_ready(rdy_n), .csr_wr_data(csr_wr_data),
    .csr_rd_data(rd_n), .trap_valid(trap_valid), .trap_priv(trap_priv),
    .trap_pc(trap_pc), .ret_priv(ret_priv), .ret_target(ret_n));

  function automatic int idx(input logic [1:0] p);
    case (p)
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic logic [W-1:0] wlegal(input logic [W-1:0] v, input bit hc);
    return hc ? {v[W-1:1], 1'b0} : {v[W-1:2], 2'b00};
  endfunction

  function automatic logic [W-1:0] rlegal(input logic [W-1:0] v, input bit hc, input bit ce);
    return (hc && ce) ? {v[W-1:1], 1'b0} : {v[W-1:2], 2'b00};
  endfunction

  function automatic logic [W-1:0] model_rd(input bit hc, input logic [1:0] p, input bit ce);
    int i;
    i = idx(p);
    if (i < 0) return '0;
    return rlegal(hc ? exp_c[i] : exp_n[i], hc, ce);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic apply(input bit ce, input logic [1:0] cp, input bit wv,
                       input logic [W-1:0] wd, input bit tv, input logic [1:0] tp,
                       input logic [W-1:0] tpc, input logic [1:0] rp);
    bit er;
    int ti, ci;
    @(negedge clk);
    c_enable = ce; csr_priv = cp; csr_wr_valid = wv; csr_wr_data = wd;
    trap_valid = tv; trap_priv = tp; trap_pc = tpc; ret_priv = rp;
    #1;
    er = !(tv && (tp == cp) && (cp != 2'b10));
    chk("R8", {{(W-1){1'b0}}, rdy_c}, {{(W-1){1'b0}}, er});
    chk(cp == 2'b10 ? "R7" : (ce ? "R4" : "R5"), rd_c, model_rd(1'b1, cp, ce));
    chk("R6", ret_c, model_rd(1'b1, rp, ce));
    chk("R3", rd_n, model_rd(1'b0, cp, ce));
    chk("R3", ret_n, model_rd(1'b0, rp, ce));
    ti = idx(tp);
    ci = idx(cp);
    if (wv && er && ci >= 0) begin
      exp_c[ci] = wlegal(wd, 1'b1);
      exp_n[ci] = wlegal(wd, 1'b0);
    end
    if (tv && ti >= 0) begin
      exp_c[ti] = wlegal(tpc, 1'b1);
      exp_n[ti] = wlegal(tpc, 1'b0);
    end
  endtask

  task automatic idle_read(input bit ce, input logic [1:0] p);
    apply(ce, p, 1'b0, '0, 1'b0, 2'b00, '0, p);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin exp_c[i] = '0; exp_n[i] = '0; end
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset value on every privilege
    idle_read(1'b1, 2'b00);
    chk("R1", rd_c, '0);
    idle_read(1'b1, 2'b01);
    chk("R1", ret_c, '0);
    idle_read(1'b1, 2'b11);
    chk("R1", rd_c, '0);

    // R2 / R4: write odd value with compression off, bit 1 hidden, then shown
    apply(1'b0, 2'b11, 1'b1, 32'h8000_0007, 1'b0, 2'b00, '0, 2'b11);
    idle_read(1'b0, 2'b11);
    chk("R5", rd_c, 32'h8000_0004);
    idle_read(1'b1, 2'b11);
    chk("R4", rd_c, 32'h8000_0006);
    chk("R2", ret_c, 32'h8000_0006);
    chk("R3", rd_n, 32'h8000_0004);

    // R8: trap and CSR write on same privilege; CSR to other privilege also
    apply(1'b1, 2'b01, 1'b1, 32'h1111_1113, 1'b1, 2'b01, 32'h2222_2223, 2'b01);
    idle_read(1'b1, 2'b01);
    chk("R8", rd_c, 32'h2222_2222);
    apply(1'b1, 2'b00, 1'b1, 32'h3333_3333, 1'b1, 2'b11, 32'h4444_4445, 2'b11);
    idle_read(1'b1, 2'b00);
    chk("R8", rd_c, 32'h3333_3332);
    chk("R9", ret_c, 32'h3333_3332);

    // R7: reserved code writes nothing and reads zero
    apply(1'b1, 2'b10, 1'b1, 32'hFFFF_FFFF, 1'b1, 2'b10, 32'hFFFF_FFFF, 2'b10);
    idle_read(1'b1, 2'b10);
    chk("R7", rd_c, '0);
    idle_read(1'b1, 2'b11);
    chk("R7", rd_c, 32'h4444_4444);

    for (int n = 0; n < 4000; n++) begin
      apply(1'($urandom), 2'($urandom), 1'($urandom), $urandom,
            ($urandom % 4) == 0, 2'($urandom), $urandom, 2'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule